// File: doc/BRIEF.md
# Serial Byte Echo Port (8N1)

This block pairs an asynchronous serial receiver with a serial transmitter. Together they handle frames of one start bit, eight data bits and one stop bit, with no parity. Bit timing comes from a counter that divides the system clock. The default is a 50 MHz clock and 9600 baud, which gives 5208 clocks per bit. A registered echo stage between the two halves sends every correctly received byte back out on the serial output.

The receiver first brings the line through a two-flop synchroniser. It then waits for a falling edge and confirms the start bit at its midpoint. After that it samples each data bit at the centre of its bit time and checks the stop bit. Each good frame appears as a byte plus a strobe that lasts exactly one system clock. On every other cycle the byte port reads zero. The echo stage registers that strobe and byte into the transmit request. The transmitter ignores any request that arrives while it is still sending a frame.

Top module: `uart_echo_top`

## Requirements
- R1: The serial output idles high. A frame is one low start bit, then data bits 0 to 7 with the LSB first, then one high stop bit. Each bit lasts CLKS_PER_BIT system clocks.
- R2: A valid frame on the serial input yields its data byte on the receive byte port, with the receive strobe high for exactly one clock.
- R3: The receive byte port reads 8'h00 on every cycle where the receive strobe is low.
- R4: On the clock after the receive strobe is high, the transmit strobe is high and the transmit byte equals the received byte. After any cycle where the receive strobe is low, the transmit strobe is low and the transmit byte is 8'h00.
- R5: Every byte the receiver accepts, when the transmitter is idle, is sent back on the serial output as one R1 frame carrying the same value.
- R6: A low pulse on the serial input shorter than half a bit time produces no receive strobe.
- R7: A frame whose stop bit is sampled low produces no receive strobe.
- R8: A transmit request that arrives while a frame is being sent is dropped. No extra frame follows the current one.
- R9: After reset the serial output is high, both strobes are low and both byte ports read 8'h00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ser_rx_i | input | 1 | Asynchronous serial input |
| rx_byte_o | output | 8 | Received byte, zero when no strobe |
| rx_rdy_o | output | 1 | One-clock strobe for a good frame |
| ser_tx_o | output | 1 | Serial output |
| tx_byte_o | output | 8 | Echo byte passed to the transmitter |
| tx_rdy_o | output | 1 | Echo request strobe |

## Verification
A receive counter or shift register that is out of step shows up as a wrong byte, or as a missing or doubled strobe. This appears within one frame time, about ten bit times. A transmitter state error shows up as a wrong bit level at a bit centre, or as a frame that never ends. The bench decodes each output bit at its midpoint, so such an error is seen inside the bit time where it occurs. An echo stage that holds stale data shows up one clock after any strobe, or one clock after any quiet cycle.

// File: rtl/uart_echo_pkg.sv
package uart_echo_pkg;
    typedef enum logic [1:0] {
        LN_IDLE  = 2'd0,
        LN_START = 2'd1,
        LN_DATA  = 2'd2,
        LN_STOP  = 2'd3
    } ln_state_e;
endpackage

// File: rtl/uart_echo_rx.sv
module uart_echo_rx
    import uart_echo_pkg::*;
#(
    parameter int CLKS_PER_BIT = 5208
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       ser_i,
    output logic [7:0] data_o,
    output logic       rdy_o
);
    localparam int CNT_W = $clog2(CLKS_PER_BIT);
    localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(CLKS_PER_BIT - 1);
    localparam logic [CNT_W-1:0] HALF_LAST = CNT_W'(CLKS_PER_BIT / 2 - 1);

    typedef struct packed {
        ln_state_e      st;
        logic [CNT_W-1:0] cnt;
        logic [2:0]     idx;
        logic [7:0]     sh;
        logic [7:0]     data;
        logic           rdy;
        logic           s1;
        logic           s2;
    } rx_reg_t;

    localparam rx_reg_t RX_RST = '{st: LN_IDLE, cnt: '0, idx: '0, sh: '0,
                                   data: '0, rdy: 1'b0, s1: 1'b1, s2: 1'b1};

    rx_reg_t rx_d, rx_q;

    always_comb begin
        rx_d      = rx_q;
        rx_d.s1   = ser_i;
        rx_d.s2   = rx_q.s1;
        rx_d.rdy  = 1'b0;
        rx_d.data = 8'h00;
        rx_d.cnt  = rx_q.cnt + 1'b1;
        case (rx_q.st)
            LN_IDLE: begin
                rx_d.cnt = '0;
                if (!rx_q.s2) rx_d.st = LN_START;
            end
            LN_START: begin
                if (rx_q.cnt == HALF_LAST) begin
                    rx_d.cnt = '0;
                    rx_d.idx = 3'd0;
                    rx_d.st  = rx_q.s2 ? LN_IDLE : LN_DATA;
                end
            end
            LN_DATA: begin
                if (rx_q.cnt == BIT_LAST) begin
                    rx_d.cnt = '0;
                    rx_d.sh  = {rx_q.s2, rx_q.sh[7:1]};
                    rx_d.idx = rx_q.idx + 3'd1;
                    if (rx_q.idx == 3'd7) rx_d.st = LN_STOP;
                end
            end
            default: begin
                if (rx_q.cnt == BIT_LAST) begin
                    rx_d.cnt = '0;
                    rx_d.st  = LN_IDLE;
                    if (rx_q.s2) begin
                        rx_d.rdy  = 1'b1;
                        rx_d.data = rx_q.sh;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) rx_q <= RX_RST;
        else       rx_q <= rx_d;
    end

    assign data_o = rx_q.data;
    assign rdy_o  = rx_q.rdy;
endmodule

// File: rtl/uart_echo_tx.sv
module uart_echo_tx
    import uart_echo_pkg::*;
#(
    parameter int CLKS_PER_BIT = 5208
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [7:0] data_i,
    input  logic       vld_i,
    output logic       ser_o
);
    localparam int CNT_W = $clog2(CLKS_PER_BIT);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(CLKS_PER_BIT - 1);

    typedef struct packed {
        ln_state_e        st;
        logic [CNT_W-1:0] cnt;
        logic [2:0]       idx;
        logic [7:0]       sh;
        logic             txd;
    } tx_reg_t;

    localparam tx_reg_t TX_RST = '{st: LN_IDLE, cnt: '0, idx: '0, sh: '0, txd: 1'b1};

    tx_reg_t tx_d, tx_q;

    always_comb begin
        tx_d     = tx_q;
        tx_d.cnt = tx_q.cnt + 1'b1;
        case (tx_q.st)
            LN_IDLE: begin
                tx_d.cnt = '0;
                tx_d.txd = 1'b1;
                if (vld_i) begin
                    tx_d.sh  = data_i;
                    tx_d.st  = LN_START;
                    tx_d.txd = 1'b0;
                end
            end
            LN_START: begin
                if (tx_q.cnt == BIT_LAST) begin
                    tx_d.cnt = '0;
                    tx_d.idx = 3'd0;
                    tx_d.txd = tx_q.sh[0];
                    tx_d.st  = LN_DATA;
                end
            end
            LN_DATA: begin
                if (tx_q.cnt == BIT_LAST) begin
                    tx_d.cnt = '0;
                    tx_d.idx = tx_q.idx + 3'd1;
                    if (tx_q.idx == 3'd7) begin
                        tx_d.st  = LN_STOP;
                        tx_d.txd = 1'b1;
                    end else begin
                        tx_d.sh  = {1'b0, tx_q.sh[7:1]};
                        tx_d.txd = tx_q.sh[1];
                    end
                end
            end
            default: begin
                if (tx_q.cnt == BIT_LAST) begin
                    tx_d.cnt = '0;
                    tx_d.st  = LN_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) tx_q <= TX_RST;
        else       tx_q <= tx_d;
    end

    assign ser_o = tx_q.txd;
endmodule

// File: rtl/uart_echo_stage.sv
module uart_echo_stage (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic [7:0] in_data_i,
    input  logic       in_rdy_i,
    output logic [7:0] out_data_o,
    output logic       out_vld_o
);
    typedef struct packed {
        logic [7:0] data;
        logic       vld;
    } echo_reg_t;

    echo_reg_t echo_d, echo_q;

    always_comb begin
        echo_d.vld  = in_rdy_i;
        echo_d.data = in_rdy_i ? in_data_i : 8'h00;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) echo_q <= '0;
        else       echo_q <= echo_d;
    end

    assign out_data_o = echo_q.data;
    assign out_vld_o  = echo_q.vld;
endmodule

// File: rtl/uart_echo_top.sv
module uart_echo_top #(
    parameter int CLK_HZ       = 50_000_000,
    parameter int BAUD         = 9600,
    parameter int CLKS_PER_BIT = CLK_HZ / BAUD
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       ser_rx_i,
    output logic [7:0] rx_byte_o,
    output logic       rx_rdy_o,
    output logic       ser_tx_o,
    output logic [7:0] tx_byte_o,
    output logic       tx_rdy_o
);
    uart_echo_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) rx_i (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .ser_i (ser_rx_i),
        .data_o(rx_byte_o),
        .rdy_o (rx_rdy_o)
    );

    uart_echo_stage echo_i (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .in_data_i (rx_byte_o),
        .in_rdy_i  (rx_rdy_o),
        .out_data_o(tx_byte_o),
        .out_vld_o (tx_rdy_o)
    );

    uart_echo_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) tx_i (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .data_i(tx_byte_o),
        .vld_i (tx_rdy_o),
        .ser_o (ser_tx_o)
    );
endmodule

// File: rtl/uart_echo_chk.sv
module uart_echo_chk (
    input logic       clk_i,
    input logic       rst_i,
    input logic [7:0] rx_byte_o,
    input logic       rx_rdy_o,
    input logic       ser_tx_o,
    input logic [7:0] tx_byte_o,
    input logic       tx_rdy_o
);
    AST_RX_PULSE_ONE: assert property (@(posedge clk_i) disable iff (rst_i)
        rx_rdy_o |=> !rx_rdy_o); // R2

    AST_RX_QUIET_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
        !rx_rdy_o |-> (rx_byte_o == 8'h00)); // R3

    AST_ECHO_COPY: assert property (@(posedge clk_i) disable iff (rst_i)
        rx_rdy_o |=> (tx_rdy_o && (tx_byte_o == $past(rx_byte_o)))); // R4

    AST_ECHO_QUIET: assert property (@(posedge clk_i) disable iff (rst_i)
        !rx_rdy_o |=> (!tx_rdy_o && (tx_byte_o == 8'h00))); // R4

    AST_RESET_IDLE: assert property (@(posedge clk_i)
        rst_i |=> (ser_tx_o && !rx_rdy_o && !tx_rdy_o)); // R9
endmodule

bind uart_echo_top uart_echo_chk chk_i (
    .clk_i    (clk_i),
    .rst_i    (rst_i),
    .rx_byte_o(rx_byte_o),
    .rx_rdy_o (rx_rdy_o),
    .ser_tx_o (ser_tx_o),
    .tx_byte_o(tx_byte_o),
    .tx_rdy_o (tx_rdy_o)
);

// File: tb/uart_echo_top_tb.sv
module uart_echo_top_tb_top;
    localparam int CPB = 16;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ser_rx = 1'b1;
    logic [7:0] rx_byte, tx_byte;
    logic       rx_rdy, tx_rdy, ser_tx;

    int n_chk = 0, n_fail = 0;
    int rx_cnt = 0, tx_cnt = 0, tx_err = 0;
    int r2_viol = 0, r3_viol = 0, r4_viol = 0;
    logic [7:0] rx_last = 8'h00, tx_last = 8'h00;
    logic       prev_rdy = 1'b0;
    logic [7:0] prev_byte = 8'h00;

    always #10 clk = ~clk;

    uart_echo_top #(.CLKS_PER_BIT(CPB)) dut_i (
        .clk_i    (clk),
        .rst_i    (rst),
        .ser_rx_i (ser_rx),
        .rx_byte_o(rx_byte),
        .rx_rdy_o (rx_rdy),
        .ser_tx_o (ser_tx),
        .tx_byte_o(tx_byte),
        .tx_rdy_o (tx_rdy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // stop_len cycles of stop level; stop_hi selects its level
    task automatic send(input logic [7:0] b, input bit stop_hi, input int stop_len);
        @(negedge clk) ser_rx = 1'b0;
        repeat (CPB) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            ser_rx = b[i];
            repeat (CPB) @(negedge clk);
        end
        ser_rx = stop_hi;
        repeat (stop_len) @(negedge clk);
        ser_rx = 1'b1;
    endtask

    // port monitor: R2 width, R3 zero, R4 echo
    always @(negedge clk) begin
        if (!rst) begin
            if (rx_rdy) begin
                rx_cnt++;
                rx_last = rx_byte;
                if (prev_rdy) r2_viol++;
            end else if (rx_byte != 8'h00) r3_viol++;
            if (prev_rdy) begin
                if (!(tx_rdy && tx_byte == prev_byte)) r4_viol++;
            end else if (tx_rdy || tx_byte != 8'h00) r4_viol++;
            prev_rdy  = rx_rdy;
            prev_byte = rx_byte;
        end
    end

    // serial output decoder (R1, R5)
    initial begin
        logic [7:0] bits;
        forever begin
            @(negedge clk);
            if (!rst && ser_tx === 1'b0) begin
                repeat (CPB / 2 - 1) @(negedge clk);
                if (ser_tx !== 1'b0) tx_err++;
                for (int i = 0; i < 8; i++) begin
                    repeat (CPB) @(negedge clk);
                    bits[i] = ser_tx;
                end
                repeat (CPB) @(negedge clk);
                if (ser_tx !== 1'b1) tx_err++;
                tx_cnt++;
                tx_last = bits;
            end
        end
    end

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 190000) begin
                n_chk++;
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
                finish_run();
            end
        end
    end

    initial begin
        int rb, tb;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(ser_tx == 1'b1, "R9 ser_tx", ser_tx, 1);
        chk(!rx_rdy && !tx_rdy, "R9 strobes", {rx_rdy, tx_rdy}, 0);
        chk(rx_byte == 8'h00 && tx_byte == 8'h00, "R9 bytes", {rx_byte, tx_byte}, 0);

        // R2 R5 R1: exhaustive byte sweep
        for (int v = 0; v < 256; v++) begin
            rb = rx_cnt; tb = tx_cnt;
            send(8'(v), 1'b1, CPB);
            repeat (11 * CPB) @(negedge clk);
            chk(rx_cnt == rb + 1, "R2 strobe count", rx_cnt - rb, 1);
            chk(rx_last == 8'(v), "R2 byte", rx_last, v);
            chk(tx_cnt == tb + 1, "R5 echo count", tx_cnt - tb, 1);
            chk(tx_last == 8'(v), "R5 echo byte", tx_last, v);
        end
        chk(tx_err == 0, "R1 start/stop levels", tx_err, 0);

        // R6 short glitch
        rb = rx_cnt;
        @(negedge clk) ser_rx = 1'b0;
        repeat (4) @(negedge clk);
        ser_rx = 1'b1;
        repeat (20 * CPB) @(negedge clk);
        chk(rx_cnt == rb, "R6 glitch ignored", rx_cnt - rb, 0);

        // R7 low stop bit
        rb = rx_cnt; tb = tx_cnt;
        send(8'hA5, 1'b0, 10);
        repeat (20 * CPB) @(negedge clk);
        chk(rx_cnt == rb, "R7 bad stop no strobe", rx_cnt - rb, 0);
        chk(tx_cnt == tb, "R7 bad stop no echo", tx_cnt - tb, 0);

        // R8 second byte arrives while echo of first is on the line
        rb = rx_cnt; tb = tx_cnt;
        send(8'h3C, 1'b1, 12);
        send(8'hC3, 1'b1, CPB);
        repeat (25 * CPB) @(negedge clk);
        chk(rx_cnt == rb + 2, "R8 both received", rx_cnt - rb, 2);
        chk(rx_last == 8'hC3, "R8 second byte", rx_last, 8'hC3);
        chk(tx_cnt == tb + 1, "R8 one echo only", tx_cnt - tb, 1);
        chk(tx_last == 8'h3C, "R8 echo of first", tx_last, 8'h3C);
        chk(ser_tx == 1'b1, "R8 line idle", ser_tx, 1);

        // R1 R8: echo path recovers
        tb = tx_cnt;
        send(8'h81, 1'b1, CPB);
        repeat (11 * CPB) @(negedge clk);
        chk(tx_cnt == tb + 1 && tx_last == 8'h81, "R1 frame after recovery", tx_last, 8'h81);
        chk(tx_err == 0, "R1 frame levels", tx_err, 0);

        chk(r2_viol == 0, "R2 one-clock strobe", r2_viol, 0);
        chk(r3_viol == 0, "R3 zero when quiet", r3_viol, 0);
        chk(r4_viol == 0, "R4 echo register", r4_viol, 0);

        // R9 reset mid-frame
        @(negedge clk) ser_rx = 1'b0;
        repeat (3 * CPB) @(negedge clk);
        rst = 1'b1;
        ser_rx = 1'b1;
        repeat (3) @(negedge clk);
        chk(ser_tx == 1'b1 && !rx_rdy && !tx_rdy, "R9 reset mid-frame", {ser_tx, rx_rdy, tx_rdy}, 4);
        finish_run();
    end
endmodule